// File: doc/BRIEF.md
# Two-Channel Current DAC Control Register Slave

This block is the serial-bus side of a two-channel sink/source current DAC. It watches the I2C clock and data lines from inside a faster system clock domain, recognises START, repeated START and STOP, answers to one fixed device address and holds one 8-bit control register per channel. A bus master writes a register by sending the device address, a register pointer and one data byte. It reads back by sending the address with the read bit set, after which the block returns the register named by the last pointer byte.

Each register is decoded into three outputs for its channel: a direction flag (sink or source), a 7-bit magnitude, and a drive enable that is low whenever the magnitude is zero. The analog side uses these directly. The block only pulls SDA low or releases it; the pad and its pull-up are outside.

Top module: `i2c_dac_regs`

## Requirements
- R1: The block answers to the 7-bit address 1001000 (byte 90h to write, 91h to read). Any other address byte gets no ACK, and every later byte is ignored (no ACK, no register change) until the next START.
- R2: Pointer F8h selects the channel 0 register and F9h the channel 1 register. A write to one leaves the other channel's outputs unchanged.
- R3: Register bit 7 drives the direction output (0 = sink, 1 = source). Bits 6:0 drive the 7-bit magnitude output.
- R4: A channel's drive enable is high exactly when its magnitude is non-zero, whatever the direction bit is.
- R5: After reset both registers hold 00h, all enables are low, SDA is released and the read pointer is F8h.
- R6: In a write, the address byte, the pointer byte and the data byte are each ACKed by pulling SDA low during the ninth clock. The data byte then appears on the selected channel's outputs.
- R7: A read returns the register chosen by the most recent pointer byte, MSB first, with SDA changed only while SCL is low.
- R8: A pointer other than F8h or F9h is ACKed, as is the data byte after it, but no register changes. A read through such a pointer returns 00h.
- R9: A repeated START restarts address matching from any state, including after an address mismatch and in the middle of a write.
- R10: In a read, a master ACK makes the block send the same register again. A master NACK makes it release SDA and ignore the bus until the next START.
- R11: A write carries one data byte. Any further byte before STOP is not ACKed and changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |
| ch0_src_o | output | 1 | Channel 0 direction, 1 = source, 0 = sink |
| ch0_mag_o | output | 7 | Channel 0 magnitude |
| ch0_en_o | output | 1 | Channel 0 drive enable |
| ch1_src_o | output | 1 | Channel 1 direction, 1 = source, 0 = sink |
| ch1_mag_o | output | 7 | Channel 1 magnitude |
| ch1_en_o | output | 1 | Channel 1 drive enable |

## Verification
The two functions that can meet are bus-condition detection and the per-byte state machine. A START can arrive while the block is ignoring a foreign address or is part-way through a write, and the data line also carries the block's own ACK and read bits. The bench provokes these cases with repeated STARTs issued after a mismatched address, inside a write and before a read, and with back-to-back reads closed by ACK and then NACK. Each case is judged by the ACK bits the master samples, the bytes it reads back, and the channel outputs compared against a model kept in the bench.

// File: rtl/i2c_dac_regs.sv
module i2c_dac_regs #(
  parameter logic [6:0] DEV_ADDR = 7'h48,
  parameter logic [7:0] REG_CH0  = 8'hF8,
  parameter logic [7:0] REG_CH1  = 8'hF9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  output logic       ch0_src_o,
  output logic [6:0] ch0_mag_o,
  output logic       ch0_en_o,
  output logic       ch1_src_o,
  output logic [6:0] ch1_mag_o,
  output logic       ch1_en_o
);
  localparam logic [2:0] S_IDLE = 3'd0, S_ADDR = 3'd1, S_PTR = 3'd2,
                         S_DATA = 3'd3, S_RD = 3'd4, S_SKIP = 3'd5;

  logic [1:0] scl_sy, sda_sy;
  logic       scl_q, sda_q;
  logic [2:0] state, nxt;
  logic [3:0] cnt;
  logic [7:0] shreg, ptr, reg0, reg1;
  logic       ack_pend, nack_seen;

  wire scl_s = scl_sy[1];
  wire sda_s = sda_sy[1];
  wire start_c = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_c  = scl_s & scl_q & ~sda_q & sda_s;
  wire rise    = scl_s & ~scl_q;
  wire fall    = ~scl_s & scl_q;
  wire active  = (state != S_IDLE) && (state != S_SKIP);

  wire [7:0] rx_byte   = {shreg[6:0], sda_s};
  wire [7:0] rd_val    = (ptr == REG_CH0) ? reg0 : (ptr == REG_CH1) ? reg1 : 8'h00;
  wire [2:0] after_ack = (state == S_RD) ? S_RD : nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      nxt        <= S_IDLE;
      cnt        <= 4'd0;
      shreg      <= 8'h00;
      ptr        <= REG_CH0;
      reg0       <= 8'h00;
      reg1       <= 8'h00;
      ack_pend   <= 1'b0;
      nack_seen  <= 1'b0;
      sda_pull_o <= 1'b0;
    end else if (start_c) begin
      state      <= S_ADDR;
      cnt        <= 4'd0;
      ack_pend   <= 1'b0;
      sda_pull_o <= 1'b0;
    end else if (stop_c) begin
      state      <= S_IDLE;
      cnt        <= 4'd0;
      ack_pend   <= 1'b0;
      sda_pull_o <= 1'b0;
    end else if (active && rise) begin
      cnt <= cnt + 4'd1;
      if (cnt < 4'd8 && state != S_RD) shreg <= rx_byte;
      if (cnt == 4'd8 && state == S_RD) nack_seen <= sda_s;
      if (cnt == 4'd7 && state != S_RD) begin
        ack_pend <= 1'b1;
        case (state)
          S_ADDR: begin
            if (rx_byte[7:1] != DEV_ADDR) begin
              state    <= S_SKIP;
              ack_pend <= 1'b0;
            end else begin
              nxt <= rx_byte[0] ? S_RD : S_PTR;
            end
          end
          S_PTR: begin
            ptr <= rx_byte;
            nxt <= S_DATA;
          end
          default: begin
            if (ptr == REG_CH0) reg0 <= rx_byte;
            else if (ptr == REG_CH1) reg1 <= rx_byte;
            nxt <= S_SKIP;
          end
        endcase
      end
    end else if (active && fall) begin
      if (cnt == 4'd8) begin
        sda_pull_o <= ack_pend;
      end else if (cnt == 4'd9) begin
        cnt      <= 4'd0;
        ack_pend <= 1'b0;
        if (state == S_RD && nack_seen) begin
          state      <= S_SKIP;
          sda_pull_o <= 1'b0;
        end else begin
          state <= after_ack;
          if (after_ack == S_RD) begin
            shreg      <= rd_val;
            sda_pull_o <= ~rd_val[7];
          end else begin
            sda_pull_o <= 1'b0;
          end
        end
      end else if (state == S_RD && cnt != 4'd0) begin
        shreg      <= {shreg[6:0], 1'b0};
        sda_pull_o <= ~shreg[6];
      end
    end
  end

  assign ch0_src_o = reg0[7];
  assign ch0_mag_o = reg0[6:0];
  assign ch0_en_o  = |reg0[6:0];
  assign ch1_src_o = reg1[7];
  assign ch1_mag_o = reg1[6:0];
  assign ch1_en_o  = |reg1[6:0];
endmodule

// File: rtl/i2c_dac_regs_chk.sv
module i2c_dac_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic [2:0] state,
  input logic       sda_pull,
  input logic [7:0] reg0,
  input logic [7:0] reg1,
  input logic       ch0_en,
  input logic       ch1_en
);
  a_r5_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!ch0_en && !ch1_en && !sda_pull));

  a_r1_no_pull_when_unselected: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd0 || state == 3'd5) |-> !sda_pull);

  a_r2_write_only_in_data_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(reg0) || !$stable(reg1)) |-> ($past(state) == 3'd3));

  a_r7_sda_moves_with_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> !$past(scl_s));
endmodule

bind i2c_dac_regs i2c_dac_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .state(state), .sda_pull(sda_pull_o),
  .reg0(reg0), .reg1(reg1), .ch0_en(ch0_en_o), .ch1_en(ch1_en_o)
);

// File: tb/i2c_dac_regs_test.sv
module i2c_dac_regs_test;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_pull, ch0_src, ch1_src, ch0_en, ch1_en;
  logic [6:0] ch0_mag, ch1_mag;
  wire sda_line = sda_m & ~sda_pull;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] exp0 = 8'h00, exp1 = 8'h00, exp_ptr = 8'hF8;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_dac_regs uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_pull_o(sda_pull),
    .ch0_src_o(ch0_src), .ch0_mag_o(ch0_mag), .ch0_en_o(ch0_en),
    .ch1_src_o(ch1_src), .ch1_mag_o(ch1_mag), .ch1_en_o(ch1_en)
  );

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, expv);
    end
  endtask

  task automatic bus_start;
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(2*Q); sda_m = 1'b0; wq(2*Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(2*Q); sda_m = 1'b1; wq(2*Q);
  endtask

  task automatic put_bit(input logic b, output logic s);
    sda_m = b; wq(Q); scl_m = 1'b1; wq(Q); s = sda_line; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    logic s;
    for (int i = 7; i >= 0; i--) put_bit(b[i], s);
    put_bit(1'b1, s);
    acked = (s == 1'b0);
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      put_bit(1'b1, s);
      b[i] = s;
    end
    put_bit(nack, s);
  endtask

  task automatic check_outs(input string req);
    check({ch0_src, ch0_mag} == exp0, req, {ch0_src, ch0_mag}, exp0);
    check(ch0_en == (exp0[6:0] != 0), req, {7'd0, ch0_en}, {7'd0, exp0[6:0] != 0});
    check({ch1_src, ch1_mag} == exp1, req, {ch1_src, ch1_mag}, exp1);
    check(ch1_en == (exp1[6:0] != 0), req, {7'd0, ch1_en}, {7'd0, exp1[6:0] != 0});
  endtask

  function automatic logic [7:0] model_read();
    return (exp_ptr == 8'hF8) ? exp0 : (exp_ptr == 8'hF9) ? exp1 : 8'h00;
  endfunction

  task automatic write_reg(input logic [7:0] p, input logic [7:0] d, input string req);
    bit a0, a1, a2;
    bus_start;
    send_byte(8'h90, a0);
    send_byte(p, a1);
    send_byte(d, a2);
    bus_stop;
    check(a0 && a1 && a2, req, {5'd0, a0, a1, a2}, 8'h07);
    exp_ptr = p;
    if (p == 8'hF8) exp0 = d;
    else if (p == 8'hF9) exp1 = d;
  endtask

  task automatic read_cur(input string req);
    bit a;
    logic [7:0] v;
    bus_start;
    send_byte(8'h91, a);
    recv_byte(1'b1, v);
    bus_stop;
    check(a, req, {7'd0, a}, 8'h01);
    check(v == model_read(), req, v, model_read());
  endtask

  initial begin
    bit a0, a1, a2, a3;
    logic [7:0] v1, v2;
    wq(5);
    check(!ch0_en && !ch1_en && !sda_pull && {ch0_src, ch0_mag} == 0 && {ch1_src, ch1_mag} == 0,
          "R5 reset state", {ch0_en, ch1_en, sda_pull, 5'd0}, 8'h00);
    rst_n = 1'b1;
    wq(5);
    check_outs("R5 after reset");
    read_cur("R5 R7 pointer at reset");

    for (int v = 0; v < 256; v += 5) begin
      write_reg(((v / 5) % 2) ? 8'hF9 : 8'hF8, v[7:0], "R6 write acks");
      check_outs("R2 R3 R4 sweep");
      read_cur("R7 read back");
    end

    write_reg(8'hF8, 8'h80, "R6");
    write_reg(8'hF9, 8'h00, "R6");
    check_outs("R4 zero magnitude with source sign");
    write_reg(8'hF9, 8'h81, "R6");
    write_reg(8'hF8, 8'h7F, "R6");
    check_outs("R3 R4 extremes");

    write_reg(8'h10, 8'h55, "R8 invalid pointer acked");
    check_outs("R8 no change");
    read_cur("R8 invalid pointer reads zero");

    bus_start;
    send_byte(8'hA0, a0);
    send_byte(8'hF8, a1);
    send_byte(8'h33, a2);
    check(!a0 && !a1 && !a2, "R1 foreign address ignored", {5'd0, a0, a1, a2}, 8'h00);
    bus_start;
    send_byte(8'h90, a0);
    send_byte(8'hF8, a1);
    send_byte(8'h3C, a2);
    bus_stop;
    exp0 = 8'h3C; exp_ptr = 8'hF8;
    check(a0 && a1 && a2, "R9 restart after mismatch", {5'd0, a0, a1, a2}, 8'h07);
    check_outs("R1 R9 outputs");

    bus_start;
    send_byte(8'h90, a0);
    send_byte(8'hF9, a1);
    bus_start;
    send_byte(8'h91, a2);
    recv_byte(1'b1, v1);
    bus_stop;
    exp_ptr = 8'hF9;
    check(a0 && a1 && a2, "R9 repeated start read acks", {5'd0, a0, a1, a2}, 8'h07);
    check(v1 == exp1, "R9 repeated start read data", v1, exp1);

    bus_start;
    send_byte(8'h90, a0);
    send_byte(8'hF8, a1);
    send_byte(8'h11, a2);
    send_byte(8'h22, a3);
    bus_stop;
    exp0 = 8'h11; exp_ptr = 8'hF8;
    check(a0 && a1 && a2 && !a3, "R11 extra byte not acked", {4'd0, a0, a1, a2, a3}, 8'h0E);
    check_outs("R11 extra byte ignored");

    bus_start;
    send_byte(8'h91, a0);
    recv_byte(1'b0, v1);
    recv_byte(1'b1, v2);
    check(!sda_pull, "R10 released after NACK", {7'd0, sda_pull}, 8'h00);
    bus_stop;
    check(a0 && v1 == exp0, "R10 first read byte", v1, exp0);
    check(v2 == exp0, "R10 repeated byte after ACK", v2, exp0);

    bus_start;
    send_byte(8'h93, a0);
    recv_byte(1'b1, v1);
    bus_stop;
    check(!a0 && v1 == 8'hFF, "R1 foreign read address", v1, 8'hFF);
    check_outs("R1 final outputs");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule